// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with BCD Adjust

This block is the purely combinational arithmetic and logic stage of a small accumulator machine. It takes the current accumulator, a second operand byte, a three-bit operation code and the stored flag byte. In the same cycle it returns the next accumulator value and the next flag byte. The flag byte carries sign, zero, nibble carry, parity-or-overflow, subtract and carry bits.

A separate select input turns on the decimal-adjust path, which repairs the accumulator after a packed-BCD addition or subtraction. That path uses the nibble-carry, subtract and carry bits already held in the incoming flag byte. When it is selected, the operation code is ignored.

Register storage, operand fetch and instruction decode sit outside this block. The two flag bits that carry no meaning pass from input to output untouched.

Top module: `alu8_core`

## Requirements
- R1: With `daa_sel` low, `op_sel` picks the accumulator result: 0 gives A+B, 1 gives A+B+C_in, 2 gives A-B, 3 gives A-B-C_in (all modulo 256), 4 gives A AND B, 5 gives A XOR B, 6 gives A OR B. C_in is bit 0 of `f_in`.
- R2: `op_sel`=7 (compare) leaves `a_out` equal to `a_in`. Its flags are those of A-B with no borrow in.
- R3: For op codes 0 to 3 and 7, flag bit 2 is set exactly when the signed two's-complement result overflows.
- R4: For op codes 4 to 6, flag bit 2 is set when the result has an even number of one bits.
- R5: Flag bit 4 (H) is the carry out of bit 3 for additions and the borrow into bit 3 for subtractions and compare, counting the incoming carry for codes 1 and 3. AND sets H. XOR and OR clear H.
- R6: Flag bit 1 (N) is set by codes 2, 3 and 7 and cleared by codes 0, 1 and 4 to 6.
- R7: Flag bit 0 (C) is the carry out of bit 7 for additions and the borrow for subtractions and compare. AND, XOR and OR clear it.
- R8: Flag bit 7 (S) is bit 7 of the result, and flag bit 6 (Z) is set when the result is zero. For compare, "the result" means the difference A-B.
- R9: Flag bits 5 and 3 of `f_out` always equal the same bits of `f_in`.
- R10: Decimal adjust builds a correction in two steps. It starts at 0x06 if the low nibble of A exceeds 9 or H is set, and at zero otherwise. It then adds 0x60 if the 9-bit value A plus that first correction, shifted right by four, exceeds 9, or if C is set. The new C is set when the correction is 0x60 or more.
- R11: Decimal adjust subtracts the correction from A when N is set and adds it otherwise. H is the nibble carry or borrow of that step. N is kept, S and Z follow the result, and bit 2 gives even parity.
- R12: With `daa_sel` high, `op_sel` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Current accumulator |
| opnd | input | 8 | Second operand |
| op_sel | input | 3 | Operation code 0..7 |
| daa_sel | input | 1 | Selects decimal adjust in place of op_sel |
| f_in | input | 8 | Current flag byte |
| a_out | output | 8 | Next accumulator |
| f_out | output | 8 | Next flag byte |

## Verification
The hardest cases to reach are the carry-dependent nibble borrows of subtract-with-borrow and the decimal-adjust branch where only the nine-bit intermediate sum pushes the high correction. Each depends on a narrow band of operand values combined with a particular stored flag. The stimulus therefore sweeps every operand pair for every operation code with the incoming carry both clear and set. It then sweeps every accumulator value for decimal adjust under all eight combinations of H, N and C, while `op_sel` changes on every vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_H  = 4;
  localparam int FB_PV = 2;
  localparam int FB_N  = 1;
  localparam int FB_C  = 0;
  localparam logic [DW-1:0] PASS_MASK = 8'h28;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBC = 3'd3,
    OP_AND = 3'd4, OP_XOR = 3'd5, OP_OR  = 3'd6, OP_CMP = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          cy;
    logic          hc;
    logic          ov;
  } sum_t;

  // Split-nibble adder; subtraction is done by inverting b and the carry in.
  function automatic sum_t addsub(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                  input logic cin, input logic sub);
    logic [DW-1:0] be;
    logic [NW:0]   lo;
    logic [NW:0]   hi;
    logic          ci;
    sum_t          s;
    be = sub ? ~b : b;
    ci = cin ^ sub;
    lo = {1'b0, a[NW-1:0]} + {1'b0, be[NW-1:0]} + {{NW{1'b0}}, ci};
    hi = {1'b0, a[DW-1:NW]} + {1'b0, be[DW-1:NW]} + {{NW{1'b0}}, lo[NW]};
    s.res = {hi[NW-1:0], lo[NW-1:0]};
    s.cy  = hi[NW] ^ sub;
    s.hc  = lo[NW] ^ sub;
    s.ov  = (a[DW-1] == be[DW-1]) && (s.res[DW-1] != a[DW-1]);
    return s;
  endfunction

  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          hc,
  output logic          ov
);
  sum_t s;
  always_comb begin
    s   = addsub(a, b, cin, sub);
    res = s.res;
    cy  = s.cy;
    hc  = s.hc;
    ov  = s.ov;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] res,
  output logic          par
);
  always_comb begin
    unique case (sel)
      2'b00:   res = a & b;
      2'b01:   res = a ^ b;
      default: res = a | b;
    endcase
    par = even_par(res);
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic          h_in,
  input  logic          n_in,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          hc
);
  localparam logic [DW-1:0] LO_FIX = DW'(6);
  localparam logic [DW-1:0] HI_FIX = DW'(6) << NW;

  logic          lo_need;
  logic          hi_need;
  logic [DW:0]   mid;
  logic [DW-1:0] corr;
  sum_t          s;

  always_comb begin
    lo_need = (a[NW-1:0] > NW'(9)) || h_in;
    mid     = {1'b0, a} + {1'b0, (lo_need ? LO_FIX : '0)};
    hi_need = (mid[DW:NW] > (NW+1)'(9)) || c_in;
    corr    = (lo_need ? LO_FIX : '0) | (hi_need ? HI_FIX : '0);
    s       = addsub(a, corr, 1'b0, n_in);
    res     = s.res;
    hc      = s.hc;
    cy      = hi_need;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] a_in,
  input  logic [7:0] opnd,
  input  logic [2:0] op_sel,
  input  logic       daa_sel,
  input  logic [7:0] f_in,
  output logic [7:0] a_out,
  output logic [7:0] f_out
);
  // Named internal events, visible to the bound checker.
  logic          is_logic;
  logic          is_cmp;
  logic          sub_mode;
  logic          carry_used;
  logic [DW-1:0] ar_res, lg_res, da_res;
  logic          ar_cy, ar_hc, ar_ov, lg_par, da_cy, da_hc;
  logic [DW-1:0] result;

  assign is_logic   = op_sel[2] && (op_sel != OP_CMP);
  assign is_cmp     = (op_sel == OP_CMP);
  assign sub_mode   = op_sel[1];
  assign carry_used = op_sel[0] && !op_sel[2] && f_in[FB_C];

  alu8_arith u_arith (
    .a(a_in), .b(opnd), .cin(carry_used), .sub(sub_mode),
    .res(ar_res), .cy(ar_cy), .hc(ar_hc), .ov(ar_ov)
  );

  alu8_logic u_logic (
    .a(a_in), .b(opnd), .sel(op_sel[1:0]), .res(lg_res), .par(lg_par)
  );

  alu8_daa u_daa (
    .a(a_in), .h_in(f_in[FB_H]), .n_in(f_in[FB_N]), .c_in(f_in[FB_C]),
    .res(da_res), .cy(da_cy), .hc(da_hc)
  );

  always_comb begin
    f_out = f_in & PASS_MASK;
    if (daa_sel) begin
      result       = da_res;
      a_out        = da_res;
      f_out[FB_H]  = da_hc;
      f_out[FB_PV] = even_par(da_res);
      f_out[FB_N]  = f_in[FB_N];
      f_out[FB_C]  = da_cy;
    end else if (is_logic) begin
      result       = lg_res;
      a_out        = lg_res;
      f_out[FB_H]  = (op_sel == OP_AND);
      f_out[FB_PV] = lg_par;
      f_out[FB_N]  = 1'b0;
      f_out[FB_C]  = 1'b0;
    end else begin
      result       = ar_res;
      a_out        = is_cmp ? a_in : ar_res;
      f_out[FB_H]  = ar_hc;
      f_out[FB_PV] = ar_ov;
      f_out[FB_N]  = sub_mode;
      f_out[FB_C]  = ar_cy;
    end
    f_out[FB_S] = result[DW-1];
    f_out[FB_Z] = (result == '0);
  end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [7:0] a_in,
  input logic [7:0] opnd,
  input logic [2:0] op_sel,
  input logic       daa_sel,
  input logic [7:0] f_in,
  input logic [7:0] a_out,
  input logic [7:0] f_out
);
  logic known;
  assign known = !$isunknown({a_in, opnd, op_sel, daa_sel, f_in});

  always_comb begin
    if (known) begin
      // R2: compare never alters the accumulator
      assert_cmp_keeps_acc_R2: assert (daa_sel || op_sel != OP_CMP || a_out == a_in);
      // R9: meaningless flag bits pass straight through
      assert_pass_bits_R9: assert ((f_out & PASS_MASK) == (f_in & PASS_MASK));
      // R6: subtract flag follows the operation class
      assert_n_flag_R6: assert (daa_sel || f_out[FB_N] ==
        (op_sel == OP_SUB || op_sel == OP_SBC || op_sel == OP_CMP));
      // R4: logic ops report parity of the accumulator
      assert_logic_parity_R4: assert (daa_sel || !(op_sel inside {OP_AND, OP_XOR, OP_OR})
        || f_out[FB_PV] == ~^a_out);
      // R5: AND sets H, XOR and OR clear it
      assert_logic_h_R5: assert (daa_sel || !(op_sel inside {OP_AND, OP_XOR, OP_OR})
        || f_out[FB_H] == (op_sel == OP_AND));
      // R7: logic ops clear carry
      assert_logic_c_R7: assert (daa_sel || !(op_sel inside {OP_AND, OP_XOR, OP_OR})
        || !f_out[FB_C]);
      // R8: sign and zero follow the written accumulator outside compare
      assert_sz_R8: assert ((!daa_sel && op_sel == OP_CMP) ||
        (f_out[FB_S] == a_out[7] && f_out[FB_Z] == (a_out == 8'h00)));
      // R11: decimal adjust keeps N
      assert_daa_keeps_n_R11: assert (!daa_sel || f_out[FB_N] == f_in[FB_N]);
    end
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .a_in(a_in), .opnd(opnd), .op_sel(op_sel), .daa_sel(daa_sel),
  .f_in(f_in), .a_out(a_out), .f_out(f_out)
);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic [7:0] a_in = 8'h00, opnd = 8'h00, f_in = 8'h00;
  logic [2:0] op_sel = 3'd0;
  logic       daa_sel = 1'b0;
  logic [7:0] a_out, f_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    logic [7:0] ea;
    logic [7:0] ef;
    bit         daa;
    int         op;
  } item_t;

  item_t sb[$];
  event  pushed;

  always #10 clk = ~clk;

  alu8_core uut (
    .a_in(a_in), .opnd(opnd), .op_sel(op_sel), .daa_sel(daa_sel),
    .f_in(f_in), .a_out(a_out), .f_out(f_out)
  );

  // Reference model written from the requirements, using plain integers.
  function automatic item_t model(int a, int b, int op, bit daa, logic [7:0] f);
    item_t it;
    int r, ci, sa, sb2, sr, v;
    bit h, pv, n, c;
    it.daa = daa; it.op = op;
    ci = f[0] ? 1 : 0;
    sa = (a > 127) ? a - 256 : a;
    sb2 = (b > 127) ? b - 256 : b;
    if (daa) begin
      v = 0;
      if ((a % 16) > 9 || f[4]) v = 6;
      if (((a + v) / 16) > 9 || f[0]) v = v + 96;
      if (f[1]) begin r = a - v; h = (a % 16) < (v % 16); end
      else      begin r = a + v; h = ((a % 16) + (v % 16)) > 15; end
      r = (r + 256) % 256;
      c = (v >= 96); n = f[1];
      pv = ($countones(r[7:0]) % 2) == 0;
      it.ea = r[7:0];
    end else if (op >= 4 && op <= 6) begin
      r = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
      h = (op == 4); n = 0; c = 0;
      pv = ($countones(r[7:0]) % 2) == 0;
      it.ea = r[7:0];
    end else begin
      int k;
      k = (op == 1 || op == 3) ? ci : 0;
      if (op == 0 || op == 1) begin
        r = a + b + k; c = r > 255; h = ((a % 16) + (b % 16) + k) > 15;
        sr = sa + sb2 + k; n = 0;
      end else begin
        r = a - b - k; c = r < 0; h = ((a % 16) - (b % 16) - k) < 0;
        sr = sa - sb2 - k; n = 1;
      end
      pv = (sr > 127) || (sr < -128);
      r = (r + 512) % 256;
      it.ea = (op == 7) ? a[7:0] : r[7:0];
    end
    it.ef = {r[7], (r % 256) == 0, f[5], h, f[3], pv, n, c};
    return it;
  endfunction

  task automatic chk(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%02h b=%02h op=%0d daa=%0b f=%02h act=%02h exp=%02h",
               tag, a_in, opnd, op_sel, daa_sel, f_in, act, exp);
    end
  endtask

  task automatic drive(int a, int b, int op, bit daa, logic [7:0] f);
    a_in = a[7:0]; opnd = b[7:0]; op_sel = op[2:0]; daa_sel = daa; f_in = f;
    #1;
    sb.push_back(model(a, b, op, daa, f));
    -> pushed;
    #1;
  endtask

  // Monitor: pops each expected item and compares it field by field.
  initial begin
    forever begin
      item_t e;
      @(pushed);
      e = sb.pop_front();
      chk(a_out == e.ea, e.daa ? "R10 R12 acc" : (e.op == 7 ? "R2 acc" : "R1 acc"), a_out, e.ea);
      chk(f_out[7:6] == e.ef[7:6], "R8 S/Z", f_out, e.ef);
      chk(f_out[4] == e.ef[4], e.daa ? "R11 H" : "R5 H", f_out, e.ef);
      chk(f_out[2] == e.ef[2], e.daa ? "R11 P/V" : ((e.op >= 4 && e.op <= 6) ? "R4 P/V" : "R3 P/V"), f_out, e.ef);
      chk(f_out[1] == e.ef[1], e.daa ? "R11 N" : "R6 N", f_out, e.ef);
      chk(f_out[0] == e.ef[0], e.daa ? "R10 C" : "R7 C", f_out, e.ef);
      chk({f_out[5], f_out[3]} == {e.ef[5], e.ef[3]}, "R9 pass bits", f_out, e.ef);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=%0d exp<190000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #5;
    // Idle state: all-zero inputs add to zero with only Z set (R8, R1)
    chk(a_out == 8'h00, "R1 idle acc", a_out, 8'h00);
    chk(f_out == 8'h40, "R8 idle flags", f_out, 8'h40);
    // Directed corners
    drive(8'h9A, 0, 0, 1'b1, 8'h00);   // R10: 9A adjusts to 00 with carry
    drive(8'h7F, 1, 0, 1'b0, 8'h00);   // R3: signed overflow on add
    drive(8'h00, 0, 3, 1'b0, 8'h01);   // R5 R7: borrow chain through carry in
    drive(8'h42, 8'h42, 7, 1'b0, 8'h28); // R2 R9: equal compare
    // Exhaustive sweep: every op, both carry-in values, every operand pair
    for (int op = 0; op < 8; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a++)
          for (int b = 0; b < 256; b++)
            drive(a, b, op, 1'b0, {2'b00, a[0], 1'b0, b[0], 2'b00, ci[0]});
    // Decimal adjust sweep; op_sel varies to show it is ignored (R12)
    for (int fl = 0; fl < 8; fl++)
      for (int a = 0; a < 256; a++)
        drive(a, 255 - a, a % 8, 1'b1,
              {2'b00, a[1], fl[2], a[2], 1'b0, fl[1], fl[0]});
    #2;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule